// File: doc/BRIEF.md
# Iterative Triple-Minus-One Array

This block maps a signed two's complement operand X to the value 3*X - 1 using a purely combinational chain of identical bit cells. The operand is first sign-extended by two positions so the result never wraps, and the chain then runs from the least significant cell to the most significant one. Each cell adds three times its operand bit, a constant one and the carry arriving from the cell below.

The constant -1 is treated as a word of all ones, so every cell adds a one and no single borrow enters the bottom of the chain. Because of this, the carry between neighbouring cells can be 0, 1, 2 or 3, and it travels on two wires as a plain binary number. The result port is two bits wider than the operand. The block contains no storage and no overflow indication, so a consumer can place it anywhere in a datapath where an exact 3*X - 1 is needed.

Top module: `triple_minus_one`

## Requirements
- R1: For every operand value, `yOut`, read as a signed number of DATA_W+2 bits, equals 3*X - 1, where X is `xIn` read as a signed DATA_W-bit number.
- R2: When X is zero, every bit of `yOut` is one, which is -1.
- R3: When X is the most negative operand, -2^(DATA_W-1), `yOut` equals -3*2^(DATA_W-1) - 1 exactly, with no wrap-around.
- R4: When X is the most positive operand, 2^(DATA_W-1) - 1, `yOut` equals 3*2^(DATA_W-1) - 4 exactly.
- R5: When X is -1, meaning all operand bits are one, `yOut` equals -4. In this case the carries rise to their largest value of 3 and stay there.
- R6: The least significant bit of `yOut` is always the inverse of bit 0 of `xIn`, because the carry into the bottom cell is zero.
- R7: The top bit of `yOut`, which is the result sign, is one exactly when X is less than or equal to zero.
- R8: The result is exact at every operand width, including narrow widths such as 4 and 6 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xIn | input | DATA_W | Signed two's complement operand X |
| yOut | output | DATA_W+2 | Signed result 3*X - 1 |

## Verification
Every operand value is applied at two widths, 4 and 6 bits, and each result is compared with a signed integer reference. A few values are also checked on their own. Zero shows whether the all-ones constant is added in every cell. Minus one drives every carry to its largest value, 3. The two extreme operands show whether the sign extension and the two extra cells keep the result exact. The sweep also checks the least significant bit and the sign bit for every operand, which separates a bad carry into the first cell from a bad top cell.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  // Inter-cell carry: binary value 0..3 on two wires
  localparam int CARRY_W   = 2;
  localparam int CARRY_MAX = 3;
  typedef logic [CARRY_W-1:0] carry_t;
endpackage

// File: rtl/tmo_sign_ext.sv
module tmo_sign_ext #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10
) (
  input  logic [IN_W-1:0]  narrowIn,
  output logic [OUT_W-1:0] wideOut
);
  localparam int EXT_W = OUT_W - IN_W;

  assign wideOut[IN_W-1:0] = narrowIn;

  generate
    for (genvar k = 0; k < EXT_W; k++) begin : g_ext
      assign wideOut[IN_W+k] = narrowIn[IN_W-1];
    end
  endgenerate
endmodule

// File: rtl/tmo_cell.sv
module tmo_cell
  import tmo_pkg::*;
(
  input  logic   xBit,
  input  carry_t cIn,
  output logic   yBit,
  output carry_t cOut
);
  // Local sum = 3*xBit + 1 + cIn, range 1..7
  logic [2:0] sumVal;

  assign sumVal = {1'b0, xBit, xBit} + 3'd1 + {1'b0, cIn};
  assign yBit   = sumVal[0];
  assign cOut   = sumVal[2:1];
endmodule

// File: rtl/tmo_chain.sv
module tmo_chain
  import tmo_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0]           xExt,
  output logic [WIDTH-1:0]           yVec,
  output logic [CARRY_W*(WIDTH+1)-1:0] carryFlat
);
  carry_t carryLink [0:WIDTH];

  assign carryLink[0] = '0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      tmo_cell u_cell (
        .xBit (xExt[i]),
        .cIn  (carryLink[i]),
        .yBit (yVec[i]),
        .cOut (carryLink[i+1])
      );
    end
    for (genvar j = 0; j <= WIDTH; j++) begin : g_flat
      assign carryFlat[CARRY_W*j +: CARRY_W] = carryLink[j];
    end
  endgenerate
endmodule

// File: rtl/triple_minus_one.sv
module triple_minus_one
  import tmo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] xIn,
  output logic [DATA_W+1:0] yOut
);
  localparam int RES_W = DATA_W + 2;

  logic [RES_W-1:0]               xWide;
  logic [CARRY_W*(RES_W+1)-1:0]   carryFlat;

  tmo_sign_ext #(.IN_W(DATA_W), .OUT_W(RES_W)) u_ext (
    .narrowIn (xIn),
    .wideOut  (xWide)
  );

  tmo_chain #(.WIDTH(RES_W)) u_chain (
    .xExt      (xWide),
    .yVec      (yOut),
    .carryFlat (carryFlat)
  );
endmodule

// File: rtl/tmo_checker.sv
module tmo_checker
  import tmo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0]                 xIn,
  input logic [DATA_W+1:0]                 yOut,
  input logic [CARRY_W*(DATA_W+3)-1:0]     carryFlat
);
  localparam int RES_W = DATA_W + 2;

  always_comb begin
    if (!$isunknown(xIn) && !$isunknown(yOut)) begin
      assert_exact_R1: assert ($signed(yOut) == 3 * $signed(xIn) - 1)
        else $error("R1 result mismatch");
      assert_lsb_R6: assert (yOut[0] == ~xIn[0])
        else $error("R6 lsb mismatch");
      assert_sign_R7: assert (yOut[RES_W-1] == ($signed(xIn) <= 0))
        else $error("R7 sign mismatch");
      assert_zero_R2: assert (xIn != '0 || yOut == '1)
        else $error("R2 zero operand");
    end
    if (!$isunknown(carryFlat)) begin
      assert_cin_zero_R6: assert (carryFlat[CARRY_W-1:0] == '0)
        else $error("R6 bottom carry not zero");
    end
  end
endmodule

bind triple_minus_one tmo_checker #(.DATA_W(DATA_W)) u_tmo_checker (
  .xIn       (xIn),
  .yOut      (yOut),
  .carryFlat (carryFlat)
);

// File: tb/test_triple_minus_one.sv
module test_triple_minus_one;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int   testsRun = 0;
  int   testsFailed = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  logic [5:0] xIn6 = '0;
  logic [7:0] yOut6;
  logic [3:0] xIn4 = '0;
  logic [5:0] yOut4;

  triple_minus_one #(.DATA_W(6)) i_triple_minus_one (
    .xIn  (xIn6),
    .yOut (yOut6)
  );

  triple_minus_one #(.DATA_W(4)) i_triple_minus_one_w4 (
    .xIn  (xIn4),
    .yOut (yOut4)
  );

  task automatic check(input string req, input int got, input int exp);
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  // Apply on a rising edge, sample on the following falling edge
  task automatic apply6(input int v);
    @(posedge clk);
    xIn6 = v[5:0];
    @(negedge clk);
  endtask

  task automatic apply4(input int v);
    @(posedge clk);
    xIn4 = v[3:0];
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // Reset phase: operand held at zero, result must be -1 (R2)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset/zero w6", int'($signed(yOut6)), -1);
    check("R2 reset/zero w4", int'($signed(yOut4)), -1);
    rst = 1'b0;

    // Full sweep, 6-bit operand (R1, R6, R7, R8)
    for (int v = -32; v < 32; v++) begin
      apply6(v);
      check("R1 sweep w6", int'($signed(yOut6)), 3 * v - 1);
      check("R6 lsb w6", int'(yOut6[0]), (v % 2 == 0) ? 1 : 0);
      check("R7 sign w6", int'(yOut6[7]), (v <= 0) ? 1 : 0);
    end

    // Full sweep, 4-bit operand (R1, R8)
    for (int v = -8; v < 8; v++) begin
      apply4(v);
      check("R8 sweep w4", int'($signed(yOut4)), 3 * v - 1);
      check("R7 sign w4", int'(yOut4[5]), (v <= 0) ? 1 : 0);
    end

    // Named corner values
    apply6(0);
    check("R2 zero w6", int'(yOut6), 255);
    apply6(-32);
    check("R3 most negative w6", int'($signed(yOut6)), -97);
    apply6(31);
    check("R4 most positive w6", int'($signed(yOut6)), 92);
    apply6(-1);
    check("R5 minus one w6", int'($signed(yOut6)), -4);
    apply4(-8);
    check("R3 most negative w4", int'($signed(yOut4)), -25);
    apply4(7);
    check("R4 most positive w4", int'($signed(yOut4)), 20);
    apply4(-1);
    check("R5 minus one w4", int'($signed(yOut4)), -4);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule